// File: doc/BRIEF.md
# Programmable Interval Timer with Free-Running Divider

This block is a small timer that runs from a system tick enable pulse. A fixed prescaler turns every PRESCALE tick pulses into one base tick. A free-running 8-bit divider advances once per DIV_STEP base ticks. An 8-bit counter advances at one of four selectable rates. When the counter passes 0xFF it reloads from a modulo register and raises an interrupt request. The request stays set until an acknowledge input clears it.

Software reaches four byte registers through a simple read/write bus with a two-bit offset. Offset 0 is the divider, and any write to it clears the divider. Offset 1 is the counter. Offset 2 is the modulo reload value. Offset 3 is the control byte. Reads are combinational from the offset. The defaults, PRESCALE = 16 and DIV_STEP = 16, give a 262144 Hz base tick and a 16384 Hz divider from a 4.194304 MHz tick.

Top module: `tick_timer`

## Requirements
- R1: One base tick occurs on every PRESCALE-th clock edge that has tick_i high. No counter or divider changes on an edge where tick_i is low, apart from the effects of bus writes.
- R2: The divider (offset 0) advances by one every DIV_STEP base ticks and wraps from 0xFF to 0x00. It counts whether the timer is enabled or not.
- R3: A write of any value to offset 0 clears the divider and its base-tick sub count, so the next divider increment comes DIV_STEP base ticks later. The write wins over a same-cycle increment.
- R4: Control bit 2 enables the counter. Control bits 1..0 select the period in base ticks: 00 = 64, 01 = 1, 10 = 4, 11 = 16. While the counter is enabled, each base tick raises a sub count. On the base tick where the sub count plus one reaches or exceeds the selected period, the sub count returns to 0 and the counter advances once. While the counter is disabled, the sub count holds.
- R5: When the counter advances from 0xFF, it loads the modulo register value held before that clock edge and sets irq_o.
- R6: irq_o stays high until an edge with irq_ack high clears it. On the same edge, a new overflow wins over the acknowledge.
- R7: A write to offset 1 loads the counter and overrides an increment or overflow on the same edge. Such a write raises no interrupt.
- R8: Reads return the divider at offset 0, the counter at 1, the modulo value at 2, and {5'b0, control[2:0]} at 3. Only control bits 2..0 are stored.
- R9: After reset, all four registers read 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | System tick enable, one pulse per system tick |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_o | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge, clears irq_o |

## Verification
The bench builds the block with PRESCALE = 2 and DIV_STEP = 4, which shortens every timing chain by a factor of eight or four. With these values the slowest counter period (128 tick pulses) and a complete 8-bit divider wrap (2048 tick pulses) both fit many times into a few thousand cycles. Random writes then often land on the same edge as increments, overflows and acknowledges. Directed sequences place counter writes on overflow edges and run every rate code in turn.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int PRESCALE = 16,
  parameter int DIV_STEP = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_o,
  input  logic       irq_ack
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int DW = (DIV_STEP > 1) ? $clog2(DIV_STEP) : 1;
  localparam int SW = 7;

  logic [PW-1:0] pre_q;
  logic [DW-1:0] dsub_q;
  logic [SW-1:0] sub_q;
  logic [7:0]    div_q, cnt_q, mod_q;
  logic [2:0]    ctl_q;
  logic [SW-1:0] period;

  wire wr_div = bus_wr && bus_addr == 2'd0;
  wire wr_cnt = bus_wr && bus_addr == 2'd1;
  wire wr_mod = bus_wr && bus_addr == 2'd2;
  wire wr_ctl = bus_wr && bus_addr == 2'd3;

  wire base     = tick_i && pre_q == PW'(PRESCALE - 1);
  wire div_roll = dsub_q == DW'(DIV_STEP - 1);
  wire sub_done = (sub_q + 1'b1) >= period;
  wire step     = base && ctl_q[2] && sub_done;
  wire ovf      = step && !wr_cnt && cnt_q == 8'hFF;

  always_comb begin
    case (ctl_q[1:0])
      2'b00:   period = SW'(64);
      2'b01:   period = SW'(1);
      2'b10:   period = SW'(4);
      default: period = SW'(16);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (tick_i) pre_q <= base ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      dsub_q <= '0;
    end else if (wr_div) begin
      div_q  <= '0;
      dsub_q <= '0;
    end else if (base) begin
      dsub_q <= div_roll ? '0 : dsub_q + 1'b1;
      if (div_roll) div_q <= div_q + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_q <= '0;
    else if (base && ctl_q[2]) sub_q <= sub_done ? '0 : sub_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (wr_cnt) cnt_q <= bus_wdata;
    else if (ovf) cnt_q <= mod_q;
    else if (step) cnt_q <= cnt_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '0;
      ctl_q <= '0;
      irq_o <= 1'b0;
    end else begin
      if (wr_mod) mod_q <= bus_wdata;
      if (wr_ctl) ctl_q <= bus_wdata[2:0];
      if (ovf) irq_o <= 1'b1;
      else if (irq_ack) irq_o <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = div_q;
      2'd1:    bus_rdata = cnt_q;
      2'd2:    bus_rdata = mod_q;
      default: bus_rdata = {5'b0, ctl_q};
    endcase
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic       irq_o,
  input logic       irq_ack,
  input logic [7:0] div_q,
  input logic [7:0] cnt_q,
  input logic [7:0] mod_q,
  input logic [2:0] ctl_q
);
  // R1
  idle_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !(bus_wr && bus_addr == 2'd0) |=> $stable(div_q));

  // R3
  div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd0 |=> div_q == 8'h00);

  // R4
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[2] && !(bus_wr && bus_addr == 2'd1) |=> $stable(cnt_q));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(cnt_q) == 8'hFF && cnt_q == $past(mod_q));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !tick_i |=> !irq_o);

  // R7
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd1 |=> cnt_q == $past(bus_wdata));
endmodule

bind tick_timer tick_timer_chk u_chk (.*);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam int PS = 2;
  localparam int DS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o;
  logic       irq_ack = 1'b0;

  int checks = 0;
  int errors = 0;

  int m_pre, m_dsub, m_sub;
  logic [7:0] m_div, m_cnt, m_mod;
  logic [2:0] m_ctl;
  logic       m_irq;

  always #10 clk = ~clk;

  tick_timer #(.PRESCALE(PS), .DIV_STEP(DS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .irq_ack(irq_ack)
  );

  function automatic int period_of(logic [1:0] s);
    case (s)
      2'b00:   return 64;
      2'b01:   return 1;
      2'b10:   return 4;
      default: return 16;
    endcase
  endfunction

  task automatic model_reset();
    m_pre = 0; m_dsub = 0; m_sub = 0;
    m_div = 0; m_cnt = 0; m_mod = 0; m_ctl = 0; m_irq = 0;
  endtask

  task automatic model_edge(logic tk, logic we, logic [1:0] a, logic [7:0] d, logic ack);
    logic base, step, ovf;
    base = tk && (m_pre == PS - 1);
    step = 0; ovf = 0;
    if (tk) m_pre = base ? 0 : m_pre + 1;
    if (we && a == 2'd0) begin
      m_div = 0; m_dsub = 0;
    end else if (base) begin
      if (m_dsub == DS - 1) begin m_dsub = 0; m_div = m_div + 8'd1; end
      else m_dsub = m_dsub + 1;
    end
    if (base && m_ctl[2]) begin
      if (m_sub + 1 >= period_of(m_ctl[1:0])) begin m_sub = 0; step = 1; end
      else m_sub = m_sub + 1;
    end
    if (we && a == 2'd1) m_cnt = d;
    else if (step) begin
      if (m_cnt == 8'hFF) begin m_cnt = m_mod; ovf = 1; end
      else m_cnt = m_cnt + 8'd1;
    end
    if (ovf) m_irq = 1;
    else if (ack) m_irq = 0;
    if (we && a == 2'd2) m_mod = d;
    if (we && a == 2'd3) m_ctl = d[2:0];
  endtask

  task automatic cyc(logic tk, logic we, logic [1:0] a, logic [7:0] d, logic ack);
    @(negedge clk);
    tick_i = tk; bus_wr = we; bus_addr = a; bus_wdata = d; irq_ack = ack;
    @(posedge clk);
    model_edge(tk, we, a, d, ack);
  endtask

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    #2;
    tick_i = 0; bus_wr = 0; irq_ack = 0;
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a);
      #1;
      case (a)
        0: cmp(tag, "divider", bus_rdata, m_div);
        1: cmp(tag, "counter", bus_rdata, m_cnt);
        2: cmp(tag, "modulo", bus_rdata, m_mod);
        default: cmp(tag, "control", bus_rdata, {5'b0, m_ctl});
      endcase
    end
    cmp(tag, "irq", {7'b0, irq_o}, {7'b0, m_irq});
  endtask

  task automatic run(int n, logic tk, string tag);
    for (int i = 0; i < n; i++) begin
      cyc(tk, 0, 0, 0, 0);
      check_all(tag);
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    model_reset();
    #35;
    rst_n = 1'b1;
    check_all("R9");

    cyc(0, 1, 3, 8'h05, 0); check_all("R8");
    run(20, 0, "R1");
    run(60, 1, "R2");
    cyc(1, 1, 0, 8'h77, 0); check_all("R3");
    run(40, 1, "R3");

    cyc(0, 1, 2, 8'hA0, 0); check_all("R5");
    cyc(0, 1, 1, 8'hFE, 0); check_all("R5");
    run(8, 1, "R5");
    cyc(0, 0, 0, 0, 1); check_all("R6");
    cyc(0, 0, 0, 0, 0); check_all("R6");

    cyc(0, 1, 1, 8'hFF, 0); check_all("R7");
    for (int i = 0; i < 2 * PS; i++) begin
      cyc(1, 1, 1, 8'hFF, 0);
      check_all("R7");
    end

    for (int c = 4; c < 8; c++) begin
      cyc(0, 1, 3, 8'(c), 0); check_all("R4");
      cyc(0, 1, 1, 8'hF0, 0);
      run(300, 1, "R4");
    end
    cyc(0, 1, 3, 8'hFF, 0); check_all("R8");
    cyc(0, 1, 3, 8'h03, 0);
    run(50, 1, "R4");

    for (int i = 0; i < 6000; i++) begin
      logic tk, we, ack;
      logic [1:0] a;
      logic [7:0] d;
      tk  = ($urandom % 10) < 8;
      we  = ($urandom % 20) == 0;
      ack = ($urandom % 25) == 0;
      a   = 2'($urandom);
      d   = 8'($urandom);
      if (a == 2'd3) d[2] = ($urandom % 4) != 0;
      cyc(tk, we, a, d, ack);
      check_all("R2");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule